// File: doc/BRIEF.md
# Reorder Buffer With In-Order Retirement

This block keeps the instructions of an out-of-order core in the order they were issued, from the moment they enter the window until they retire. The issue stage claims an entry and receives its index, which becomes the tag that names the instruction's result. Functional units return results against that tag, in any order. Later instructions can read a finished result by tag while it is still speculative.

Retirement is strictly in order, one entry per cycle, from the oldest slot. A finished register-writing instruction at the head produces a register-file write. A store at the head produces a store request. A mispredicted branch at the head retires and discards everything younger. An instruction that raised an exception retires without touching any state and discards everything younger. In both cases the window is empty one cycle later, so state always matches a single point in program order.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `st_req`, `redirect`, `excp_valid` and `look_hit` are 0.
- R2: An allocation is accepted in a cycle where `alloc_valid` and `alloc_ready` are both 1. Accepted allocations receive tags 0,1,2,... in issue order, wrapping modulo DEPTH.
- R3: Once DEPTH entries are live, `alloc_ready` is 0. An allocation attempt in that state is ignored, and `alloc_tag` does not move.
- R4: A completion (`cpl_valid`) stores a value, an exception flag and a mispredict flag in the tagged entry and marks it finished. A completion aimed at a free entry has no effect.
- R5: `look_hit` is 1 with `look_value` equal to the stored result only when the entry at `look_tag` is live and finished. A newly allocated entry reads as not finished.
- R6: Only the oldest entry retires, and only once it has finished. Younger entries that finished earlier wait for it.
- R7: A retiring entry that has no exception, is not a store and has a destination raises `rf_we` for one cycle, with `rf_dst` and `rf_data` taken from the entry.
- R8: A retiring store with no exception raises `st_req` with `st_data` equal to its result and does not raise `rf_we`.
- R9: A retiring branch that completed with the mispredict flag set raises `redirect`, with `commit_pc` equal to the branch PC. One cycle later every younger entry is gone, `alloc_tag` equals the branch tag plus one, and lookups miss.
- R10: A retiring entry that completed with the exception flag set raises `excp_valid`, with `commit_pc` equal to its PC. It raises neither `rf_we` nor `st_req`, and one cycle later all younger entries are gone.
- R11: An allocation and a retirement in the same cycle leave the number of live entries unchanged.
- R12: No allocation is accepted in a cycle where `redirect` or `excp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue stage requests an entry |
| alloc_ready | output | 1 | An entry can be taken this cycle |
| alloc_pc | input | PCW | PC of the issuing instruction |
| alloc_dst | input | AREGW | Architectural destination register |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_is_branch | input | 1 | Instruction is a branch |
| alloc_is_store | input | 1 | Instruction is a store |
| alloc_tag | output | log2(DEPTH) | Tag given to the instruction if accepted |
| cpl_valid | input | 1 | A result is being returned |
| cpl_tag | input | log2(DEPTH) | Entry the result belongs to |
| cpl_value | input | XLEN | Result value (store data for stores) |
| cpl_exc | input | 1 | Instruction raised an exception |
| cpl_mispredict | input | 1 | Branch was mispredicted |
| look_tag | input | log2(DEPTH) | Entry to read for operand forwarding |
| look_hit | output | 1 | Entry is live and finished |
| look_value | output | XLEN | Stored result of that entry |
| rf_we | output | 1 | Register-file write from retirement |
| rf_dst | output | AREGW | Register being written |
| rf_data | output | XLEN | Value being written |
| st_req | output | 1 | Store released to memory |
| st_data | output | XLEN | Store data |
| commit_pc | output | PCW | PC of the entry at the head |
| redirect | output | 1 | Mispredicted branch retired; younger entries dropped |
| excp_valid | output | 1 | Excepting instruction reached the head; younger entries dropped |

## Verification
The assertions hold on every cycle. They check that a refused allocation leaves the tag pointer in place, that an accepted one moves it by exactly one, and that at most one of register write, store release and exception fires. They also check that the cycle after any flush shows an empty window with no retirement and no lookup hit. Other properties depend on data and on order, and only the bench scenarios show them. These are: retirement waits for the head even when younger results arrive first; results come out in issue order with the right values; a stale result left in a slot does not reappear after the slot is reused; and one cycle with both an allocation and a retirement keeps the occupancy the same.

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  parameter int AREGW = 5,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [PCW-1:0]   alloc_pc,
  input  logic [AREGW-1:0] alloc_dst,
  input  logic             alloc_has_dst,
  input  logic             alloc_is_branch,
  input  logic             alloc_is_store,
  output logic [IW-1:0]    alloc_tag,
  input  logic             cpl_valid,
  input  logic [IW-1:0]    cpl_tag,
  input  logic [XLEN-1:0]  cpl_value,
  input  logic             cpl_exc,
  input  logic             cpl_mispredict,
  input  logic [IW-1:0]    look_tag,
  output logic             look_hit,
  output logic [XLEN-1:0]  look_value,
  output logic             rf_we,
  output logic [AREGW-1:0] rf_dst,
  output logic [XLEN-1:0]  rf_data,
  output logic             st_req,
  output logic [XLEN-1:0]  st_data,
  output logic [PCW-1:0]   commit_pc,
  output logic             redirect,
  output logic             excp_valid
);

  logic [IW:0]       head_q, tail_q;
  logic [DEPTH-1:0]  live_q, fin_q, exc_q, mp_q, br_q, st_q, wr_q;
  logic [PCW-1:0]    pc_q  [DEPTH];
  logic [AREGW-1:0]  dst_q [DEPTH];
  logic [XLEN-1:0]   val_q [DEPTH];

  logic [IW-1:0] hidx, tidx;
  logic full, retire, flush, take, cpl_ok;

  assign hidx  = head_q[IW-1:0];
  assign tidx  = tail_q[IW-1:0];
  assign full  = (head_q[IW] != tail_q[IW]) && (hidx == tidx);

  assign retire     = live_q[hidx] && fin_q[hidx];
  assign excp_valid = retire && exc_q[hidx];
  assign redirect   = retire && !exc_q[hidx] && br_q[hidx] && mp_q[hidx];
  assign flush      = excp_valid || redirect;

  assign alloc_ready = !full && !flush;
  assign take        = alloc_valid && alloc_ready;
  assign alloc_tag   = tidx;
  assign cpl_ok      = cpl_valid && live_q[cpl_tag];

  assign look_hit   = live_q[look_tag] && fin_q[look_tag];
  assign look_value = val_q[look_tag];

  assign rf_we     = retire && !exc_q[hidx] && !st_q[hidx] && wr_q[hidx];
  assign rf_dst    = dst_q[hidx];
  assign rf_data   = val_q[hidx];
  assign st_req    = retire && !exc_q[hidx] && st_q[hidx];
  assign st_data   = val_q[hidx];
  assign commit_pc = pc_q[hidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      live_q <= '0;
      fin_q  <= '0;
      exc_q  <= '0;
      mp_q   <= '0;
    end else if (flush) begin
      live_q <= '0;
      head_q <= head_q + 1'b1;
      tail_q <= head_q + 1'b1;
    end else begin
      if (take) begin
        live_q[tidx] <= 1'b1;
        fin_q[tidx]  <= 1'b0;
        exc_q[tidx]  <= 1'b0;
        mp_q[tidx]   <= 1'b0;
        tail_q       <= tail_q + 1'b1;
      end
      if (cpl_ok) begin
        fin_q[cpl_tag] <= 1'b1;
        exc_q[cpl_tag] <= cpl_exc;
        mp_q[cpl_tag]  <= cpl_mispredict;
      end
      if (retire) begin
        live_q[hidx] <= 1'b0;
        head_q       <= head_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      pc_q[tidx]  <= alloc_pc;
      dst_q[tidx] <= alloc_dst;
      br_q[tidx]  <= alloc_is_branch;
      st_q[tidx]  <= alloc_is_store;
      wr_q[tidx]  <= alloc_has_dst;
    end
    if (cpl_ok && !flush)
      val_q[cpl_tag] <= cpl_value;
  end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [IW-1:0] alloc_tag,
  input logic          look_hit,
  input logic          rf_we,
  input logic          st_req,
  input logic          redirect,
  input logic          excp_valid
);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !redirect && !excp_valid) |=> $stable(alloc_tag));

  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_tag == $past(alloc_tag) + 1'b1));

  // R10
  one_retire_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_req, excp_valid}));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect || excp_valid) |=>
      (alloc_ready && !look_hit && !rf_we && !st_req && !redirect && !excp_valid));

  // R12
  no_alloc_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect || excp_valid) |-> !alloc_ready);

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .look_hit(look_hit), .rf_we(rf_we), .st_req(st_req),
  .redirect(redirect), .excp_valid(excp_valid)
);

// File: tb/rob_core_tb.sv
module rob_core_tb;
  localparam int DEPTH = 8;
  localparam int XLEN  = 32;
  localparam int PCW   = 32;
  localparam int AREGW = 5;
  localparam int IW    = $clog2(DEPTH);

  localparam logic [XLEN-1:0] VEC_VAL [DEPTH] = '{32'h1111_0000, 32'h2222_0101, 32'h3333_0202,
    32'h4444_0303, 32'h5555_0404, 32'h6666_0505, 32'h7777_0606, 32'h8888_0707};
  localparam logic [IW-1:0] VEC_ORDER [DEPTH] = '{3'd3, 3'd6, 3'd1, 3'd5, 3'd2, 3'd7, 3'd4, 3'd0};
  localparam int STORE_IDX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_has_dst = 0, alloc_is_branch = 0, alloc_is_store = 0;
  logic [PCW-1:0] alloc_pc = '0;
  logic [AREGW-1:0] alloc_dst = '0;
  logic cpl_valid = 0, cpl_exc = 0, cpl_mispredict = 0;
  logic [IW-1:0] cpl_tag = '0, look_tag = '0;
  logic [XLEN-1:0] cpl_value = '0;
  logic alloc_ready, look_hit, rf_we, st_req, redirect, excp_valid;
  logic [IW-1:0] alloc_tag;
  logic [XLEN-1:0] look_value, rf_data, st_data;
  logic [AREGW-1:0] rf_dst;
  logic [PCW-1:0] commit_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .XLEN(XLEN), .PCW(PCW), .AREGW(AREGW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    alloc_valid = 0; cpl_valid = 0; cpl_exc = 0; cpl_mispredict = 0;
    alloc_is_branch = 0; alloc_is_store = 0; alloc_has_dst = 0;
  endtask

  task automatic drive_alloc(input logic [PCW-1:0] pc, input logic [AREGW-1:0] d,
                             input bit hd, input bit br, input bit st);
    alloc_valid = 1; alloc_pc = pc; alloc_dst = d;
    alloc_has_dst = hd; alloc_is_branch = br; alloc_is_store = st;
  endtask

  task automatic drive_cpl(input logic [IW-1:0] t, input logic [XLEN-1:0] v, input bit ex, input bit mp);
    cpl_valid = 1; cpl_tag = t; cpl_value = v; cpl_exc = ex; cpl_mispredict = mp;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0h expected %0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    eq("R1 ready", alloc_ready, 1);
    eq("R1 tag", alloc_tag, 0);
    eq("R1 quiet", {rf_we, st_req, redirect, excp_valid, look_hit}, 0);

    // R2: table walk, fill the buffer
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      drive_alloc(32'h100 + 4 * i, AREGW'(i + 1), 1, 0, i == STORE_IDX);
      #1 eq("R2 tag order", alloc_tag, i);
      tick();
    end
    @(negedge clk);
    eq("R3 full ready", alloc_ready, 0);
    drive_alloc(32'hDEAD, 5'd30, 1, 0, 0);
    tick();
    @(negedge clk);
    eq("R3 ignored tag", alloc_tag, 0);
    eq("R3 still full", alloc_ready, 0);
    look_tag = 3'd0;
    #1 eq("R5 miss unfinished", look_hit, 0);

    // R6: complete out of order, head last
    for (int k = 0; k < DEPTH - 1; k++) begin
      @(negedge clk);
      drive_cpl(VEC_ORDER[k], VEC_VAL[VEC_ORDER[k]], 0, 0);
      tick();
      @(negedge clk);
      eq("R6 no early retire", {rf_we, st_req}, 0);
    end
    look_tag = 3'd3;
    #1 eq("R5 hit", look_hit, 1);
    eq("R5 value", look_value, VEC_VAL[3]);
    drive_cpl(3'd0, VEC_VAL[0], 0, 0);
    tick();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      if (i == STORE_IDX) begin
        eq("R8 st_req", {st_req, rf_we}, 2'b10);
        eq("R8 st_data", st_data, VEC_VAL[i]);
      end else begin
        eq("R7 rf_we", {rf_we, st_req}, 2'b10);
        eq("R7 rf_dst", rf_dst, i + 1);
        eq("R7 rf_data", rf_data, VEC_VAL[i]);
      end
      tick();
    end
    @(negedge clk);
    eq("R6 drained", {alloc_ready, rf_we, st_req}, 3'b100);

    // R11: seven live entries, alloc and retire together
    for (int i = 0; i < DEPTH - 1; i++) begin
      @(negedge clk);
      drive_alloc(32'h200 + 4 * i, AREGW'(i + 10), i != 1, i == 1, 0);
      tick();
    end
    @(negedge clk);
    drive_cpl(3'd0, 32'hA0, 0, 0);
    tick();
    @(negedge clk);
    drive_alloc(32'h21C, 5'd20, 1, 0, 0);
    #1 eq("R11 retire same cycle", rf_we, 1);
    eq("R11 tag", alloc_tag, 7);
    tick();
    @(negedge clk);
    eq("R11 occupancy kept", alloc_ready, 1);
    drive_alloc(32'h220, 5'd21, 1, 0, 0);
    tick();
    @(negedge clk);
    eq("R11 now full", alloc_ready, 0);

    // R9: mispredicted branch at tag 1
    drive_cpl(3'd3, 32'h33, 0, 0);
    tick();
    @(negedge clk);
    drive_cpl(3'd1, 32'h0, 0, 1);
    tick();
    @(negedge clk);
    eq("R9 redirect", redirect, 1);
    eq("R9 pc", commit_pc, 32'h204);
    eq("R12 no ready in flush", alloc_ready, 0);
    tick();
    @(negedge clk);
    look_tag = 3'd3;
    #1 eq("R9 younger dropped", look_hit, 0);
    eq("R9 tag after", alloc_tag, 2);
    eq("R9 ready", alloc_ready, 1);

    // R10: exception at tag 2
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      drive_alloc(32'h300 + 4 * i, AREGW'(i + 1), 1, 0, i == 2);
      tick();
    end
    @(negedge clk);
    drive_cpl(3'd3, 32'hAA, 0, 0);
    tick();
    @(negedge clk);
    drive_cpl(3'd2, 32'hBB, 1, 0);
    tick();
    @(negedge clk);
    eq("R10 excp", excp_valid, 1);
    eq("R10 pc", commit_pc, 32'h300);
    eq("R10 no state", {rf_we, st_req}, 0);
    tick();
    @(negedge clk);
    look_tag = 3'd3;
    #1 eq("R10 younger dropped", look_hit, 0);
    eq("R10 tag after", alloc_tag, 3);

    // R4: completion to a free slot
    drive_cpl(3'd6, 32'h66, 0, 0);
    tick();
    @(negedge clk);
    look_tag = 3'd6;
    #1 eq("R4 free slot ignored", look_hit, 0);

    // R5/R7: slot reuse
    drive_alloc(32'h400, 5'd9, 1, 0, 0);
    tick();
    @(negedge clk);
    look_tag = 3'd3;
    #1 eq("R5 reused slot unfinished", look_hit, 0);
    drive_cpl(3'd3, 32'h1234, 0, 0);
    tick();
    @(negedge clk);
    eq("R7 reuse write", {rf_we, rf_dst}, {1'b1, 5'd9});
    eq("R7 reuse data", rf_data, 32'h1234);
    tick();
    finish_run();
  end
endmodule